// File: doc/BRIEF.md
# Retirement-Stage Program Counter

This block holds the architectural program counter as one register in the memory-access stage of an in-order pipeline. Earlier stages and fetch-buffer rows carry no instruction address. Whenever a valid instruction sits in that stage, the register holds that instruction's own address. Any instruction that needs its address reads it from here: branches, jumps, link-value writers and PC-relative adds.

The register changes only when an instruction retires. A retiring control transfer loads its target, with bit 0 cleared so the value stays halfword aligned. Any other retiring instruction advances the register by its own length: 4 bytes for a full-width encoding and 2 bytes for a compressed one. The length comes from the two lowest opcode bits. A combinational sequential-next output gives the address of the following instruction, for use as a link or return value.

All pins are plain control and data. The block has no ready output and never applies back-pressure. The retire strobe is sampled on every rising clock edge. When it is low, because of a bubble or a stall upstream, the register simply keeps its value.

Top module: `rp_retire_pc`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads the register with `boot_addr`, bit 0 cleared. `cur_pc` shows this value after the first such edge.
- R2: On an edge where `retire_vld` is low, `cur_pc` keeps its value, whatever `xfer_vld`, `xfer_tgt` and `op_lo` are.
- R3: On an edge where `retire_vld` is high, `xfer_vld` is low and `op_lo` equals 2'b11 (a 32-bit encoding), `cur_pc` advances by 4.
- R4: On an edge where `retire_vld` is high, `xfer_vld` is low and `op_lo` is 2'b00, 2'b01 or 2'b10 (a 16-bit encoding), `cur_pc` advances by 2.
- R5: On an edge where `retire_vld` and `xfer_vld` are both high, `cur_pc` loads `xfer_tgt` with bit 0 cleared. The transfer wins over the increment for every `op_lo` value.
- R6: `seq_pc` equals `cur_pc` plus 4 when `op_lo` is 2'b11 and plus 2 otherwise. It follows `op_lo` combinationally, within the same cycle.
- R7: Bit 0 of `cur_pc` is always zero once the first reset edge has occurred.
- R8: All address arithmetic wraps modulo 2^32, so 32'hFFFF_FFFE + 2 gives 0 and 32'hFFFF_FFFC + 4 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_addr | input | 32 | Address loaded while in reset |
| retire_vld | input | 1 | An instruction in the stage retires on this edge |
| xfer_vld | input | 1 | The retiring instruction is a taken control transfer |
| xfer_tgt | input | 32 | Target address of the control transfer |
| op_lo | input | 2 | Two lowest opcode bits of the retiring instruction |
| cur_pc | output | 32 | Address of the instruction in the stage |
| seq_pc | output | 32 | Address of the instruction that follows it in sequence |

## Verification
The hardest conditions to reach from the ports are the wrap-around at the top of the address space and the case where a transfer and a full-width length arrive on the same edge. The register reaches these values only after a transfer has set it near the boundary.

The bench therefore first loads each of several base addresses through a transfer, some of them with odd targets. These bases include 32'hFFFF_FFFC and 32'hFFFF_FFFE. From each base it sweeps every combination of retire strobe, transfer flag and the four `op_lo` codes. An arithmetic model runs alongside to give the expected current and next address.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int unsigned PC_W     = 32;
  localparam int unsigned OPLO_W   = 2;
  localparam int unsigned STEP_W   = 3;
  localparam logic [OPLO_W-1:0] OPLO_FULL = 2'b11;
  localparam logic [STEP_W-1:0] STEP_HALF = 3'd2;
  localparam logic [STEP_W-1:0] STEP_FULL = 3'd4;

  typedef enum logic [1:0] {
    UPD_HOLD = 2'b00,
    UPD_SEQ  = 2'b01,
    UPD_XFER = 2'b10
  } upd_sel_e;
endpackage

// File: rtl/rp_len_decode.sv
module rp_len_decode
  import rp_pkg::*;
(
  input  logic [OPLO_W-1:0] op_lo,
  output logic [STEP_W-1:0] step
);
  always_comb begin
    if (op_lo == OPLO_FULL) step = STEP_FULL;
    else                    step = STEP_HALF;
  end
endmodule

// File: rtl/rp_seq_adder.sv
module rp_seq_adder
  import rp_pkg::*;
#(
  parameter int unsigned W = PC_W
) (
  input  logic [W-1:0]      base,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      sum
);
  localparam int unsigned PAD_W = W - STEP_W;
  logic [W-1:0] step_ext;
  generate
    if (PAD_W > 0) begin : g_pad
      assign step_ext = {{PAD_W{1'b0}}, step};
    end else begin : g_nopad
      assign step_ext = step[W-1:0];
    end
  endgenerate
  assign sum = base + step_ext;
endmodule

// File: rtl/rp_state_reg.sv
module rp_state_reg
  import rp_pkg::*;
#(
  parameter int unsigned W = PC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] boot_addr,
  input  logic         retire_vld,
  input  logic         xfer_vld,
  input  logic [W-1:0] xfer_tgt,
  input  logic [W-1:0] seq_addr,
  output logic [W-1:0] pc_q
);
  upd_sel_e     sel;
  logic [W-1:0] pc_d;

  always_comb begin
    if (!retire_vld)   sel = UPD_HOLD;
    else if (xfer_vld) sel = UPD_XFER;
    else               sel = UPD_SEQ;
  end

  always_comb begin
    unique case (sel)
      UPD_XFER: pc_d = {xfer_tgt[W-1:1], 1'b0};
      UPD_SEQ:  pc_d = seq_addr;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= {boot_addr[W-1:1], 1'b0};
    else        pc_q <= pc_d;
  end

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_vld |=> $stable(pc_q));

  // R5
  pc_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && xfer_vld) |=> (pc_q == {$past(xfer_tgt[W-1:1]), 1'b0}));

  // R7
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[0] == 1'b0);
endmodule

// File: rtl/rp_retire_pc.sv
module rp_retire_pc
  import rp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   boot_addr,
  input  logic              retire_vld,
  input  logic              xfer_vld,
  input  logic [PC_W-1:0]   xfer_tgt,
  input  logic [OPLO_W-1:0] op_lo,
  output logic [PC_W-1:0]   cur_pc,
  output logic [PC_W-1:0]   seq_pc
);
  logic [STEP_W-1:0] step;
  logic [PC_W-1:0]   pc_q;

  rp_len_decode u_len (
    .op_lo (op_lo),
    .step  (step)
  );

  rp_seq_adder #(.W(PC_W)) u_add (
    .base (pc_q),
    .step (step),
    .sum  (seq_pc)
  );

  rp_state_reg #(.W(PC_W)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_addr  (boot_addr),
    .retire_vld (retire_vld),
    .xfer_vld   (xfer_vld),
    .xfer_tgt   (xfer_tgt),
    .seq_addr   (seq_pc),
    .pc_q       (pc_q)
  );

  assign cur_pc = pc_q;

  // R6
  seq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_pc - cur_pc) == ((op_lo == OPLO_FULL) ? 32'd4 : 32'd2));

  // R3 R4
  seq_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_vld && !xfer_vld) |=> (cur_pc == $past(seq_pc)));
endmodule

// File: tb/rp_retire_pc_tb.sv
module rp_retire_pc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] boot_addr;
  logic        retire_vld;
  logic        xfer_vld;
  logic [31:0] xfer_tgt;
  logic [1:0]  op_lo;
  logic [31:0] cur_pc;
  logic [31:0] seq_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  rp_retire_pc u_dut (
    .clk(clk), .rst_n(rst_n), .boot_addr(boot_addr), .retire_vld(retire_vld),
    .xfer_vld(xfer_vld), .xfer_tgt(xfer_tgt), .op_lo(op_lo),
    .cur_pc(cur_pc), .seq_pc(seq_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] len_of(input logic [1:0] o);
    return (o == 2'b11) ? 32'd4 : 32'd2;
  endfunction

  task automatic step(input logic rv, input logic xv, input logic [31:0] tgt,
                      input logic [1:0] o);
    string tag;
    @(negedge clk);
    retire_vld = rv; xfer_vld = xv; xfer_tgt = tgt; op_lo = o;
    #1;
    check("R6 seq_pc", seq_pc, model + len_of(o));
    @(posedge clk);
    if (!rv)     begin model = model;                 tag = "R2 hold"; end
    else if (xv) begin model = {tgt[31:1], 1'b0};     tag = "R5 xfer"; end
    else         begin model = model + len_of(o);
                       tag = (o == 2'b11) ? "R3 +4" : "R4 +2"; end
    #1;
    check(tag, cur_pc, model);
    check("R7 align", {31'd0, cur_pc[0]}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] bases [6];
    bases[0] = 32'h0000_0000; bases[1] = 32'h0000_1001;
    bases[2] = 32'hFFFF_FFFC; bases[3] = 32'hFFFF_FFFF;
    bases[4] = 32'h7FFF_FFFE; bases[5] = 32'h8000_0003;
    rst_n = 1'b0; boot_addr = 32'h0000_2003; retire_vld = 1'b1;
    xfer_vld = 1'b1; xfer_tgt = 32'h5555_5555; op_lo = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    check("R1 boot", cur_pc, 32'h0000_2002);
    @(negedge clk);
    boot_addr = 32'h0000_0100;
    @(posedge clk); #1;
    check("R1 boot reload", cur_pc, 32'h0000_0100);
    @(negedge clk);
    rst_n = 1'b1; retire_vld = 1'b0; xfer_vld = 1'b0;
    model = 32'h0000_0100;

    // R8 wrap corners
    step(1'b1, 1'b1, 32'hFFFF_FFFE, 2'b00);
    step(1'b1, 1'b0, 32'h0, 2'b01);
    check("R8 wrap +2", cur_pc, 32'h0000_0000);
    step(1'b1, 1'b1, 32'hFFFF_FFFC, 2'b11);
    step(1'b1, 1'b0, 32'h0, 2'b11);
    check("R8 wrap +4", cur_pc, 32'h0000_0000);

    foreach (bases[b]) begin
      for (int rv = 0; rv < 2; rv++)
        for (int xv = 0; xv < 2; xv++)
          for (int o = 0; o < 4; o++) begin
            step(1'b1, 1'b1, bases[b], 2'b10);
            step(rv[0], xv[0], bases[b] ^ 32'h0000_0F0F, o[1:0]);
          end
    end

    // R2 hold over a long stall with varying side inputs
    for (int k = 0; k < 16; k++)
      step(1'b0, k[0], 32'hDEAD_0000 + k, k[1:0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule